// File: doc/BRIEF.md
# Sequence Trigger and Conflict Controller

This block decides which of four command sequences is allowed to run. A start request can come from a host command write or from any of eight general-purpose pins. Each pin can be routed to one of the four sequences and set to react either to a rising edge or to a high level. At most one sequence runs at a time. Any request that cannot be honoured is dropped rather than queued, and each dropped request sets a sticky ignored flag for its sequence, which drives an interrupt.

A global enable gates all execution, and a halt input pauses the running sequence so that its completion is not taken. While a sequence runs, the sequencer can toggle pins that are set up as synchronisation outputs, which can pace external devices. A single done input stands in for the end of the sequence program. The outputs give the identifier of the running sequence, a one-cycle start pulse and a go level for the execution engine.

Top module: `seq_trig_ctrl`

## Requirements
- R1: While reset is high at a clock edge, busy, seq_start, run_id, ign_flags and sync_out are all cleared, and irq and seq_go are low.
- R2: A pin with trig_en=1, oe=0 and edge_mode=1 starts the sequence given by its 2-bit field pin_map[2p+1:2p] on a rising edge. The pin passes through two synchroniser flops, so busy rises after the third rising clock edge that follows the pin change. A pin that is held high triggers only once.
- R3: A pin with trig_en=1, oe=0 and edge_mode=0 requests its mapped sequence whenever its synchronised value is high and nothing runs. While a sequence runs, a level request is held off and sets no ignored flag, so a pin that stays high starts its sequence again in the first idle cycle.
- R4: A pin with oe=1 or with trig_en=0 never starts a sequence and never sets an ignored flag.
- R5: With enable=1 and nothing running, a host_req bit starts that sequence. At the next edge busy=1, run_id holds the sequence number (0 to 3), and seq_start is high for exactly that one cycle.
- R6: A host or edge request that arrives while a sequence runs is discarded. The running sequence and its run_id are not changed, and the ignored flag of the requested sequence is set.
- R7: When several requests arrive together with nothing running, the lowest-numbered sequence starts and the others are discarded with their ignored flags set.
- R8: ign_flags bit s stays set until a cycle with irq_clr[s]=1 clears it. A set and a clear on the same bit in the same cycle leave the bit set.
- R9: When done is high with halt low, busy falls at the next edge, and the block is idle in the following cycle.
- R10: While halt is high, done is not taken, busy stays high and seq_go is low. seq_go equals busy with halt low.
- R11: While enable is low, no request starts a sequence and no request sets a flag. Clearing enable during a run ends the run at the next edge.
- R12: A sync_wr while busy XORs sync_out with sync_data, but only on pins that have both sync_en=1 and oe=1. A sync_wr while idle leaves sync_out unchanged.
- R13: irq is high exactly when at least one ign_flags bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Global execution enable |
| cfg_halt | input | 1 | Pause the running sequence |
| host_req | input | 4 | Host start request, one bit per sequence |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_oe | input | 8 | 1 = the pin is driven as an output |
| pin_trig_en | input | 8 | 1 = the pin may trigger a sequence |
| pin_edge | input | 8 | 1 = rising-edge detection, 0 = level detection |
| pin_map | input | 16 | Target sequence of pin p in bits [2p+1:2p] |
| pin_sync_en | input | 8 | 1 = the pin is a synchronisation output |
| sync_wr | input | 1 | Sequencer write to the toggle register |
| sync_data | input | 8 | Mask of pins to toggle |
| seq_done | input | 1 | The running sequence has finished |
| irq_clr | input | 4 | Write-1-to-clear mask for ign_flags |
| seq_start | output | 1 | One-cycle pulse when a sequence starts |
| busy | output | 1 | A sequence is running |
| run_id | output | 2 | Identifier of the running (or last) sequence |
| seq_go | output | 1 | The engine may advance (busy and not halted) |
| ign_flags | output | 4 | Sticky ignored-request flags |
| irq | output | 1 | Interrupt, OR of ign_flags |
| sync_out | output | 8 | Toggled synchronisation pin levels |

## Verification
The assertions assume that reset is held for at least one clock edge before it is released, and that all control inputs are stable around each rising edge. They do not assume any order among requests, done, halt and enable, so any mix of these inputs is legal. The stimulus changes every input 1 ns after a rising edge and holds reset for three edges. It changes the pin routing only while nothing runs, so the model and the design always decode the same configuration. It deliberately overlaps requests with runs, halts, clears and disabled periods.

// File: rtl/seq_trig_pkg.sv
package seq_trig_pkg;

    localparam int SEQ_N = 4;
    localparam int SEQ_W = $clog2(SEQ_N);

    typedef logic [SEQ_W-1:0] seq_id_t;
    typedef logic [SEQ_N-1:0] seq_vec_t;

    // state of the one execution slot
    typedef struct packed {
        logic    busy;
        seq_id_t id;
    } run_t;

    // outcome of one arbitration round
    typedef struct packed {
        logic     win;
        seq_id_t  id;
        seq_vec_t lose;
    } grant_t;

    function automatic seq_vec_t id_to_vec(input seq_id_t id);
        seq_vec_t v;
        v = '0;
        v[id] = 1'b1;
        return v;
    endfunction

    // lowest index wins, every other set bit is a loser
    function automatic grant_t pick_lowest(input seq_vec_t r);
        grant_t g;
        g = '0;
        for (int i = SEQ_N - 1; i >= 0; i--) begin
            if (r[i]) begin
                g.win = 1'b1;
                g.id  = seq_id_t'(i);
            end
        end
        g.lose = g.win ? (r & ~id_to_vec(g.id)) : '0;
        return g;
    endfunction

endpackage

// File: rtl/seq_pin_detect.sv
module seq_pin_detect
    import seq_trig_pkg::*;
#(
    parameter int NUM_PIN     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_PIN-1:0]       pin_in,
    input  logic [NUM_PIN-1:0]       pin_oe,
    input  logic [NUM_PIN-1:0]       pin_trig_en,
    input  logic [NUM_PIN-1:0]       pin_edge,
    input  logic [NUM_PIN*SEQ_W-1:0] pin_map,
    output seq_vec_t                 edge_req,
    output seq_vec_t                 lvl_req
);

    logic [NUM_PIN-1:0] cur;
    logic [NUM_PIN-1:0] prev;

    // per-pin synchroniser plus one history flop for edge detection
    for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
        logic [SYNC_STAGES:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[SYNC_STAGES-1:0], pin_in[p]};
        end
        assign cur[p]  = chain[SYNC_STAGES-1];
        assign prev[p] = chain[SYNC_STAGES];
    end

    // fold pin events onto the sequence they are routed to
    always_comb begin
        edge_req = '0;
        lvl_req  = '0;
        for (int p = 0; p < NUM_PIN; p++) begin
            if (pin_trig_en[p] && !pin_oe[p]) begin
                if (pin_edge[p]) begin
                    if (cur[p] && !prev[p])
                        edge_req[pin_map[p*SEQ_W +: SEQ_W]] = 1'b1;
                end else if (cur[p]) begin
                    lvl_req[pin_map[p*SEQ_W +: SEQ_W]] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/seq_arbiter.sv
module seq_arbiter
    import seq_trig_pkg::*;
(
    input  logic     enable,
    input  logic     busy,
    input  seq_vec_t host_req,
    input  seq_vec_t edge_req,
    input  seq_vec_t lvl_req,
    output grant_t   grant,
    output seq_vec_t drop
);

    seq_vec_t cand;

    // level requests wait quietly for an idle slot
    assign cand = busy ? (host_req | edge_req) : (host_req | edge_req | lvl_req);

    always_comb begin
        grant = '0;
        drop  = '0;
        if (enable) begin
            if (!busy) begin
                grant = pick_lowest(cand);
                drop  = grant.lose;
            end else begin
                drop = cand;
            end
        end
    end

endmodule

// File: rtl/seq_sync_toggle.sv
module seq_sync_toggle #(
    parameter int NUM_PIN = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [NUM_PIN-1:0] mask,
    input  logic [NUM_PIN-1:0] sync_en,
    input  logic [NUM_PIN-1:0] oe,
    output logic [NUM_PIN-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (wr_en) q <= q ^ (mask & sync_en & oe);
    end

endmodule

// File: rtl/seq_trig_ctrl.sv
module seq_trig_ctrl
    import seq_trig_pkg::*;
#(
    parameter int NUM_PIN     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_enable,
    input  logic                     cfg_halt,
    input  logic [SEQ_N-1:0]         host_req,
    input  logic [NUM_PIN-1:0]       pin_in,
    input  logic [NUM_PIN-1:0]       pin_oe,
    input  logic [NUM_PIN-1:0]       pin_trig_en,
    input  logic [NUM_PIN-1:0]       pin_edge,
    input  logic [NUM_PIN*SEQ_W-1:0] pin_map,
    input  logic [NUM_PIN-1:0]       pin_sync_en,
    input  logic                     sync_wr,
    input  logic [NUM_PIN-1:0]       sync_data,
    input  logic                     seq_done,
    input  logic [SEQ_N-1:0]         irq_clr,
    output logic                     seq_start,
    output logic                     busy,
    output logic [SEQ_W-1:0]         run_id,
    output logic                     seq_go,
    output logic [SEQ_N-1:0]         ign_flags,
    output logic                     irq,
    output logic [NUM_PIN-1:0]       sync_out
);

    seq_vec_t edge_req, lvl_req, drop;
    grant_t   grant;
    run_t     run_q;
    logic     start_q;
    seq_vec_t flags_q;
    logic     finish;

    seq_pin_detect #(.NUM_PIN(NUM_PIN), .SYNC_STAGES(SYNC_STAGES)) u_detect (
        .clk         (clk),
        .rst         (rst),
        .pin_in      (pin_in),
        .pin_oe      (pin_oe),
        .pin_trig_en (pin_trig_en),
        .pin_edge    (pin_edge),
        .pin_map     (pin_map),
        .edge_req    (edge_req),
        .lvl_req     (lvl_req)
    );

    seq_arbiter u_arb (
        .enable   (cfg_enable),
        .busy     (run_q.busy),
        .host_req (host_req),
        .edge_req (edge_req),
        .lvl_req  (lvl_req),
        .grant    (grant),
        .drop     (drop)
    );

    seq_sync_toggle #(.NUM_PIN(NUM_PIN)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (sync_wr && run_q.busy),
        .mask    (sync_data),
        .sync_en (pin_sync_en),
        .oe      (pin_oe),
        .q       (sync_out)
    );

    // a run ends on completion (not halted) or when execution is disabled
    assign finish = run_q.busy && (!cfg_enable || (seq_done && !cfg_halt));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= grant.win;
            if (grant.win)   run_q <= '{busy: 1'b1, id: grant.id};
            else if (finish) run_q.busy <= 1'b0;
        end
    end

    // sticky flags: a new drop outranks a clear on the same bit
    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~irq_clr) | drop;
    end

    assign seq_start = start_q;
    assign busy      = run_q.busy;
    assign run_id    = run_q.id;
    assign seq_go    = run_q.busy && !cfg_halt;
    assign ign_flags = flags_q;
    assign irq       = |flags_q;

endmodule

// File: rtl/seq_trig_chk.sv
module seq_trig_chk #(
    parameter int NUM_PIN = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               cfg_enable,
    input logic               cfg_halt,
    input logic               seq_done,
    input logic [3:0]         irq_clr,
    input logic               seq_start,
    input logic               busy,
    input logic [1:0]         run_id,
    input logic [3:0]         ign_flags,
    input logic [NUM_PIN-1:0] sync_out
);

    AST_START_MEANS_BUSY: assert property (@(posedge clk) disable iff (rst)
        seq_start |-> busy);  // R5

    AST_ID_HELD_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        (busy && !seq_start) |-> $stable(run_id));  // R6

    AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !cfg_enable |=> !seq_start);  // R11

    AST_HALT_KEEPS_RUN: assert property (@(posedge clk) disable iff (rst)
        (busy && cfg_halt && cfg_enable) |=> busy);  // R10

    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
        (busy && seq_done && !cfg_halt) |=> !busy);  // R9

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(ign_flags) & ~$past(irq_clr) & ~ign_flags) == 4'b0));  // R8

    AST_SYNC_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !busy |=> (sync_out == $past(sync_out)));  // R12

endmodule

bind seq_trig_ctrl seq_trig_chk #(.NUM_PIN(NUM_PIN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_enable (cfg_enable),
    .cfg_halt   (cfg_halt),
    .seq_done   (seq_done),
    .irq_clr    (irq_clr),
    .seq_start  (seq_start),
    .busy       (busy),
    .run_id     (run_id),
    .ign_flags  (ign_flags),
    .sync_out   (sync_out)
);

// File: tb/tb_seq_trig_ctrl.sv
`timescale 1ns/1ps
module tb_seq_trig_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_enable = 1'b1, cfg_halt = 1'b0;
    logic [3:0]  host_req = '0, irq_clr = '0;
    logic [7:0]  pin_in = '0, pin_oe, pin_trig_en, pin_edge, pin_sync_en;
    logic [15:0] pin_map;
    logic        sync_wr = 1'b0, seq_done = 1'b0;
    logic [7:0]  sync_data = '0;
    logic        seq_start, busy, seq_go, irq;
    logic [1:0]  run_id;
    logic [3:0]  ign_flags;
    logic [7:0]  sync_out;

    int    n_run = 0, n_fail = 0, cyc = 0;
    string phase = "R1";

    // expected state kept by the reference model
    logic [7:0] m_s1, m_s2, m_s3, m_sync;
    logic       m_busy, m_start;
    logic [1:0] m_id;
    logic [3:0] m_flags;

    always #5 clk = ~clk;

    seq_trig_ctrl dut (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_halt(cfg_halt),
        .host_req(host_req), .pin_in(pin_in), .pin_oe(pin_oe),
        .pin_trig_en(pin_trig_en), .pin_edge(pin_edge), .pin_map(pin_map),
        .pin_sync_en(pin_sync_en), .sync_wr(sync_wr), .sync_data(sync_data),
        .seq_done(seq_done), .irq_clr(irq_clr), .seq_start(seq_start),
        .busy(busy), .run_id(run_id), .seq_go(seq_go), .ign_flags(ign_flags),
        .irq(irq), .sync_out(sync_out)
    );

    // reference model, advanced on every rising edge
    always @(posedge clk) begin
        logic [3:0] e_r, l_r, all, set;
        logic       nb, ns;
        logic [1:0] nid;
        int         w, sq;
        cyc++;
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_s3 = '0; m_sync = '0;
            m_busy = 0; m_start = 0; m_id = '0; m_flags = '0;
        end else begin
            e_r = '0; l_r = '0;
            for (int p = 0; p < 8; p++) begin
                sq = int'(pin_map[2*p +: 2]);
                if (pin_trig_en[p] && !pin_oe[p]) begin
                    if (pin_edge[p]) begin
                        if (m_s2[p] && !m_s3[p]) e_r[sq] = 1'b1;
                    end else if (m_s2[p]) l_r[sq] = 1'b1;
                end
            end
            set = '0; ns = 0; nb = m_busy; nid = m_id;
            if (cfg_enable) begin
                if (!m_busy) begin
                    all = host_req | e_r | l_r;
                    w = -1;
                    for (int s = 0; s < 4; s++) if (all[s] && w < 0) w = s;
                    if (w >= 0) begin
                        ns = 1; nb = 1; nid = 2'(w);
                        set = all & ~(4'b1 << w);
                    end
                end else begin
                    set = host_req | e_r;
                    if (seq_done && !cfg_halt) nb = 0;
                end
            end else if (m_busy) nb = 0;
            if (sync_wr && m_busy) m_sync = m_sync ^ (sync_data & pin_sync_en & pin_oe);
            m_flags = (m_flags & ~irq_clr) | set;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_in;
            m_busy = nb; m_start = ns; m_id = nid;
        end
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", phase, what, cyc, act, exp);
        end
    endtask

    // compare away from the active edge
    always @(negedge clk) begin
        if (cyc >= 1) begin
            chk("busy", 32'(busy), 32'(m_busy));
            chk("seq_start", 32'(seq_start), 32'(m_start));
            chk("run_id", 32'(run_id), 32'(m_id));
            chk("ign_flags", 32'(ign_flags), 32'(m_flags));
            chk("irq R13", 32'(irq), 32'(m_flags != 0));
            chk("seq_go", 32'(seq_go), 32'(m_busy && !cfg_halt));
            chk("sync_out", 32'(sync_out), 32'(m_sync));
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic host(logic [3:0] r);
        host_req = r; step(1); host_req = '0;
    endtask

    task automatic done_pulse();
        seq_done = 1'b1; step(1); seq_done = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // pin p routes to sequence p%4; pins 6,7 outputs; pin 5 trigger off
        for (int p = 0; p < 8; p++) pin_map[2*p +: 2] = 2'(p % 4);
        pin_oe      = 8'b1100_0000;
        pin_trig_en = 8'b1101_1111;
        pin_edge    = 8'b0001_0011;
        pin_sync_en = 8'b0110_0000;
        phase = "R1"; step(3); rst = 1'b0; step(3);

        phase = "R5"; host(4'b0100); step(4);
        phase = "R9"; done_pulse(); step(3);

        phase = "R2"; pin_in[0] = 1'b1; step(10);
        done_pulse(); step(6); pin_in[0] = 1'b0; step(4);

        phase = "R3"; pin_in[2] = 1'b1; step(6);
        done_pulse(); step(5); pin_in[2] = 1'b0; step(4);
        done_pulse(); step(3);

        phase = "R4"; pin_in[6] = 1'b1; pin_in[5] = 1'b1; step(8);
        pin_in[6] = 1'b0; pin_in[5] = 1'b0; step(3);

        phase = "R6"; host(4'b0010); step(2); host(4'b1000); step(2);
        pin_in[4] = 1'b1; step(5); pin_in[4] = 1'b0; done_pulse(); step(3);

        phase = "R7"; host(4'b1110); step(3); done_pulse(); step(2);

        phase = "R8"; irq_clr = 4'b0100; step(1); irq_clr = '0; step(2);
        host(4'b0001); step(1);
        host_req = 4'b1000; irq_clr = 4'b1000; step(1);
        host_req = '0; irq_clr = '0; step(2);
        irq_clr = 4'b1111; step(1); irq_clr = '0; done_pulse(); step(2);

        phase = "R10"; host(4'b0001); step(2);
        cfg_halt = 1'b1; step(2); done_pulse(); step(3);
        cfg_halt = 1'b0; step(2); done_pulse(); step(3);

        phase = "R11"; cfg_enable = 1'b0; host(4'b0011); step(3);
        cfg_enable = 1'b1; host(4'b0100); step(3);
        cfg_enable = 1'b0; step(3); cfg_enable = 1'b1; step(2);

        phase = "R12"; sync_data = 8'hFF;
        sync_wr = 1'b1; step(1); sync_wr = 1'b0; step(1);
        host(4'b1000); step(1);
        sync_wr = 1'b1; step(1); sync_wr = 1'b0; step(2);
        sync_wr = 1'b1; step(2); sync_wr = 1'b0; step(1);
        done_pulse(); step(2);

        phase = "R1"; rst = 1'b1; step(2); rst = 1'b0; step(3);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule